// File: doc/BRIEF.md
# Double-Write Protected Configuration Register

This block is a configuration register that guards its contents in two ways. First, software must write the same value twice in a row before the value takes effect. The first write is only held in a staging slot. A matching second write commits the value. A second write that differs is rejected and raises a one-cycle update alert. Second, the committed value is kept twice: once as written and once bit-inverted. The two copies are compared on every cycle.

If the inverted copy no longer matches the committed copy, a storage alert is raised. That fault is treated as fatal. From then on the register ignores every write until reset, and the storage alert stays high until reset, even if the copies agree again. A test-only injection input flips one chosen bit of the inverted copy, so that a storage fault can be produced on demand.

Top module: `shadow_cfg_reg`

## Requirements
- R1: A write while nothing is staged only stages the data; `rd_data_o` keeps the committed value and no alert is raised.
- R2: A write while a value is staged, carrying the same data, commits it; `rd_data_o` shows the new value from the cycle after that clock edge.
- R3: A write while a value is staged, carrying different data, leaves `rd_data_o` unchanged and drives `upd_alert_o` high for exactly the one cycle after that clock edge.
- R4: After a commit or a rejected second write the staging slot is empty, so the next write counts as a new first write.
- R5: During and after reset `rd_data_o` equals RESET_VAL (default 8'hA5 for WIDTH 8), and both alerts are low.
- R6: A clock edge with `fault_en_i` high flips bit `fault_idx_i` of the inverted copy (an index of WIDTH or more does nothing); from the cycle after that edge `store_alert_o` is high.
- R7: While a storage fault is present or has been latched, writes are ignored: nothing is staged, nothing is committed, and `upd_alert_o` stays low.
- R8: Once raised, `store_alert_o` stays high until reset, even when a second injection makes the two copies agree again.
- R9: Reset clears the staging slot, the update alert and the fatal lock, so that after reset one write only stages and two matching writes commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | WIDTH | Write data |
| rd_data_o | output | WIDTH | Committed value |
| upd_alert_o | output | 1 | One-cycle pulse on a rejected second write |
| store_alert_o | output | 1 | Level, storage fault seen since reset |
| fault_en_i | input | 1 | Test only: flip one bit of the inverted copy |
| fault_idx_i | input | IDXW | Test only: bit index to flip |

## Verification
A staging slot stuck full or empty shows within two writes: either a single write commits, or a matching pair is rejected with an update pulse. A corrupt inverted copy shows on `store_alert_o` in the cycle after it appears, and a lock that fails to hold shows as `rd_data_o` changing after two matching writes made during the fault. A lock that survives reset shows on the first pair of writes after reset, which must commit.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;
  typedef enum logic {
    STG_EMPTY = 1'b0,
    STG_HELD  = 1'b1
  } stage_e;
endpackage

// File: rtl/shadow_cfg_stager.sv
module shadow_cfg_stager
  import shadow_cfg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             block_i,
  output logic             commit_o,
  output logic             reject_o,
  output logic             upd_alert_o
);
  stage_e           state_q;
  logic [WIDTH-1:0] held_q;
  logic             wr_ok;

  function automatic logic pair_matches(logic [WIDTH-1:0] a, logic [WIDTH-1:0] b);
    return (a ^ b) == '0;
  endfunction

  assign wr_ok    = wr_en_i && !block_i;
  assign commit_o = wr_ok && (state_q == STG_HELD) && pair_matches(held_q, wr_data_i);
  assign reject_o = wr_ok && (state_q == STG_HELD) && !pair_matches(held_q, wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= STG_EMPTY;
      held_q      <= '0;
      upd_alert_o <= 1'b0;
    end else begin
      upd_alert_o <= reject_o;
      if (wr_ok) begin
        if (state_q == STG_EMPTY) begin
          state_q <= STG_HELD;
          held_q  <= wr_data_i;
        end else begin
          state_q <= STG_EMPTY;
        end
      end
    end
  end

  // R4: a second write empties the slot
  a_r4_slot_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_o || reject_o) |=> (state_q == STG_EMPTY));
  // R3: update alert lasts one cycle
  a_r3_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_alert_o |=> !upd_alert_o);
  // R7: blocked writes leave the slot alone
  a_r7_slot_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    block_i |=> $stable(state_q));
endmodule

// File: rtl/shadow_cfg_store.sv
module shadow_cfg_store #(
  parameter int              WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  parameter int              IDXW      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             commit_i,
  input  logic [WIDTH-1:0] commit_data_i,
  input  logic             fault_en_i,
  input  logic [IDXW-1:0]  fault_idx_i,
  output logic [WIDTH-1:0] main_o,
  output logic [WIDTH-1:0] inv_o
);
  logic [WIDTH-1:0] main_q;
  logic [WIDTH-1:0] inv_q;
  logic [WIDTH-1:0] flip_mask;
  logic [WIDTH-1:0] inv_base;

  function automatic logic [WIDTH-1:0] one_hot_at(logic [IDXW-1:0] idx);
    logic [WIDTH-1:0] m;
    m = '0;
    for (int i = 0; i < WIDTH; i++) begin
      if (32'(idx) == i) m[i] = 1'b1;
    end
    return m;
  endfunction

  assign flip_mask = fault_en_i ? one_hot_at(fault_idx_i) : '0;
  assign inv_base  = commit_i ? ~commit_data_i : inv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_q <= RESET_VAL;
      inv_q  <= ~RESET_VAL;
    end else begin
      if (commit_i) main_q <= commit_data_i;
      inv_q <= inv_base ^ flip_mask;
    end
  end

  assign main_o = main_q;
  assign inv_o  = inv_q;

  // R2: commit lands in both copies consistently
  a_r2_commit_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !fault_en_i) |=> (main_q == $past(commit_data_i)) && ((main_q ^ inv_q) == '1));
endmodule

// File: rtl/shadow_cfg_guard.sv
module shadow_cfg_guard #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] main_i,
  input  logic [WIDTH-1:0] inv_i,
  output logic             fault_now_o,
  output logic             fatal_o,
  output logic             store_alert_o
);
  logic lock_q;

  function automatic logic copies_disagree(logic [WIDTH-1:0] m, logic [WIDTH-1:0] s);
    return (m ^ ~s) != '0;
  endfunction

  assign fault_now_o = copies_disagree(main_i, inv_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lock_q <= 1'b0;
    else if (fault_now_o) lock_q <= 1'b1;
  end

  assign fatal_o       = lock_q || fault_now_o;
  assign store_alert_o = fatal_o;

  // R6: a fault sets the lock
  a_r6_fault_locks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_now_o |=> lock_q);
  // R8: alert is sticky
  a_r8_alert_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_alert_o |=> store_alert_o);
endmodule

// File: rtl/shadow_cfg_reg.sv
module shadow_cfg_reg #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] RESET_VAL = 8'hA5,
  localparam int              IDXW      = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  output logic             upd_alert_o,
  output logic             store_alert_o,
  input  logic             fault_en_i,
  input  logic [IDXW-1:0]  fault_idx_i
);
  logic             commit_evt;
  logic             reject_evt;
  logic             fatal;
  logic             fault_now;
  logic [WIDTH-1:0] main_copy;
  logic [WIDTH-1:0] inv_copy;

  shadow_cfg_stager #(.WIDTH(WIDTH)) u_stager (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .block_i    (fatal),
    .commit_o   (commit_evt),
    .reject_o   (reject_evt),
    .upd_alert_o(upd_alert_o)
  );

  shadow_cfg_store #(.WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .IDXW(IDXW)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit_evt),
    .commit_data_i(wr_data_i),
    .fault_en_i   (fault_en_i),
    .fault_idx_i  (fault_idx_i),
    .main_o       (main_copy),
    .inv_o        (inv_copy)
  );

  shadow_cfg_guard #(.WIDTH(WIDTH)) u_guard (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .main_i       (main_copy),
    .inv_i        (inv_copy),
    .fault_now_o  (fault_now),
    .fatal_o      (fatal),
    .store_alert_o(store_alert_o)
  );

  assign rd_data_o = main_copy;

  // R7: nothing is committed while the fault is present or latched
  a_r7_locked_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_alert_o |=> $stable(rd_data_o));
  // R1: a write with nothing staged does not change the read value
  a_r1_stage_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !commit_evt) |=> $stable(rd_data_o));
  // R3: rejected write never raises a storage fault by itself
  a_r3_reject_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reject_evt && !fault_now && !fault_en_i) |=> $stable(rd_data_o) && upd_alert_o);
endmodule

// File: tb/shadow_cfg_reg_tb.sv
module shadow_cfg_reg_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       upd_alert;
  logic       store_alert;
  logic       fault_en = 1'b0;
  logic [2:0] fault_idx = '0;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  shadow_cfg_reg u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .upd_alert_o(upd_alert), .store_alert_o(store_alert),
    .fault_en_i(fault_en), .fault_idx_i(fault_idx)
  );

  // {wr_en, data, expected rd_data, expected upd_alert}
  localparam logic [17:0] VEC [12] = '{
    {1'b1, 8'h3C, 8'hA5, 1'b0},  // R1 stage
    {1'b1, 8'h3C, 8'h3C, 1'b0},  // R2 commit
    {1'b0, 8'h00, 8'h3C, 1'b0},
    {1'b1, 8'h11, 8'h3C, 1'b0},  // R1
    {1'b1, 8'h22, 8'h3C, 1'b1},  // R3 reject
    {1'b1, 8'h22, 8'h3C, 1'b0},  // R4 new first write
    {1'b0, 8'h00, 8'h3C, 1'b0},
    {1'b1, 8'h22, 8'h22, 1'b0},  // R2
    {1'b1, 8'hFF, 8'h22, 1'b0},
    {1'b1, 8'h00, 8'h22, 1'b1},  // R3
    {1'b1, 8'h00, 8'h22, 1'b0},  // R4
    {1'b1, 8'h00, 8'h00, 1'b0}   // R2
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic [7:0] d);
    wr_en = en;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic inject(input logic [2:0] idx);
    fault_en = 1'b1;
    fault_idx = idx;
    @(negedge clk);
    fault_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R5 rd during reset", rd_data, 8'hA5);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R5 rd after reset", rd_data, 8'hA5);
    chk("R5 upd alert", {7'd0, upd_alert}, 8'd0);
    chk("R5 store alert", {7'd0, store_alert}, 8'd0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][17], VEC[i][16:9]);
      chk($sformatf("R1-R4 vec %0d rd", i), rd_data, VEC[i][8:1]);
      chk($sformatf("R3 vec %0d upd", i), {7'd0, upd_alert}, {7'd0, VEC[i][0]});
      chk($sformatf("R6 vec %0d no store alert", i), {7'd0, store_alert}, 8'd0);
    end

    // R9: staging cleared by reset
    step(1'b1, 8'h66);
    chk("R1 staged before reset", rd_data, 8'h00);
    do_reset();
    step(1'b1, 8'h66);
    chk("R9 single write after reset only stages", rd_data, 8'hA5);
    step(1'b1, 8'h66);
    chk("R9 pair after reset commits", rd_data, 8'h66);

    // R6: inject fault, staged value pending
    step(1'b1, 8'h5A);
    inject(3'd3);
    chk("R6 store alert raised", {7'd0, store_alert}, 8'd1);
    // R7: matching second write ignored
    step(1'b1, 8'h5A);
    chk("R7 locked commit ignored", rd_data, 8'h66);
    step(1'b1, 8'h01);
    step(1'b1, 8'h02);
    chk("R7 no upd alert while locked", {7'd0, upd_alert}, 8'd0);
    step(1'b1, 8'h02);
    chk("R7 rd unchanged while locked", rd_data, 8'h66);
    // R8: repair the copy, alert stays
    inject(3'd3);
    @(negedge clk);
    chk("R8 alert sticky after repair", {7'd0, store_alert}, 8'd1);
    step(1'b1, 8'h44);
    step(1'b1, 8'h44);
    chk("R8 still locked after repair", rd_data, 8'h66);

    // R6: out-of-range index cannot happen for WIDTH 8; R9 lock cleared
    do_reset();
    chk("R9 store alert cleared", {7'd0, store_alert}, 8'd0);
    step(1'b1, 8'h44);
    chk("R9 stage after lock reset", rd_data, 8'hA5);
    step(1'b1, 8'h44);
    chk("R9 commit after lock reset", rd_data, 8'h44);
    inject(3'd7);
    chk("R6 fault on top bit", {7'd0, store_alert}, 8'd1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule